// File: doc/BRIEF.md
# USB Type-C Downstream-Port Attach Controller

This block is the digital core of a source-only Type-C configuration-channel controller. It receives the digitised comparator results for both CC lines. For each line, one flag marks a pull-down in the sink (Rd) range and another marks one in the active-cable (Ra) range. Neither flag set means the line is open. The block filters each line over a programmable number of cycles and decides whether a sink is attached. It then takes the plug orientation from the line that carries Rd.

From that decision it drives several outputs:
- the high-speed mux select and its enable;
- the CC mux select and its enable;
- the VBUS switch enable;
- one VCONN switch control for each CC line;
- a status LED;
- a current-advertisement code decoded from two mode pins.

Two strap pins are sampled during reset and set the polarity of VBUS enable and of the VCONN controls. A long VCONN fault turns VCONN off until the cable is removed. The VBUS fault input has no effect. All pins are plain level signals with no handshake.

Top module: `tcdfp_attach_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the block is unattached: LED low, both mux enables high (inactive), both selects 0, VBUS enable and both VCONN controls at their inactive level.
- R2: A change on a CC line is accepted only after the line holds the same class (Rd wins over Ra; neither is open) for DEB_CYCLES consecutive cycles. Shorter pulses change nothing, whether the block is attached or not.
- R3: On attach, Rd on CC1 gives orientation 0 and Rd on CC2 gives orientation 1. The orientation drives both the high-speed select and the CC select. When both lines carry Rd, CC1 wins. Both selects read 0 while unattached.
- R4: The active-low high-speed and CC mux enables are driven low in exactly the cycles in which the LED is high.
- R5: While attached, the LED is high and VBUS enable is active. When the filtered selected line leaves Rd, the block returns to unattached and drops every enable.
- R6: While attached, the VCONN control of the other (unused) CC line is active only when that line reads Ra. The control of the selected line is never active.
- R7: The strap pins are captured while reset is low. Strap 0 makes the related outputs active high and strap 1 makes them active low. Strap changes after reset have no effect.
- R8: The current code follows the pins {mode_a, mode_b}: 00 gives code 00 (default), 01 gives 01 (1.5 A), 11 gives 10 (3 A), and the reserved 10 gives 00 (default).
- R9: If vconn_fault_n stays low for FAULT_CYCLES consecutive cycles while attached, both VCONN controls go inactive and stay inactive while the sink remains attached. A shorter fault leaves VCONN on.
- R10: vbus_fault_n has no effect on any output.
- R11: A detach clears the VCONN fault latch, so VCONN returns after a new attach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps are sampled while it is low |
| cc1_rd | input | 1 | CC1 comparator: Rd pull-down seen |
| cc1_ra | input | 1 | CC1 comparator: Ra pull-down seen |
| cc2_rd | input | 1 | CC2 comparator: Rd pull-down seen |
| cc2_ra | input | 1 | CC2 comparator: Ra pull-down seen |
| mode_a | input | 1 | Current-mode pin, high bit of the code |
| mode_b | input | 1 | Current-mode pin, low bit of the code |
| vbus_pol_strap | input | 1 | VBUS enable polarity strap (1 = active low) |
| vconn_pol_strap | input | 1 | VCONN control polarity strap (1 = active low) |
| vconn_fault_n | input | 1 | VCONN switch fault, active low |
| vbus_fault_n | input | 1 | VBUS switch fault, active low, ignored |
| hs_sel | output | 1 | High-speed mux select (orientation) |
| hs_oe_n | output | 1 | High-speed mux enable, active low |
| ccmux_sel | output | 1 | CC mux select (orientation) |
| ccmux_oe_n | output | 1 | CC mux enable, active low |
| vbus_en | output | 1 | VBUS switch enable, polarity from strap |
| vconn1_ctl | output | 1 | VCONN switch control for CC1, polarity from strap |
| vconn2_ctl | output | 1 | VCONN switch control for CC2, polarity from strap |
| attach_led | output | 1 | High while a sink is attached |
| cur_adv | output | 2 | Advertised current code: 00 default, 01 1.5 A, 10 3 A |

## Verification
The bench builds the block with DEB_CYCLES = 4 and FAULT_CYCLES = 32 instead of the millisecond-scale defaults. With these values, glitches shorter than the filter window and faults on either side of the trip point take only a few dozen cycles each. The filter window is short enough that a table of attach, re-orientation and detach vectors settles within 30 cycles per row. The fault window is long enough that a 24-cycle fault clearly falls inside it and a 40-cycle fault clearly exceeds it.

// File: rtl/tcdfp_pkg.sv
package tcdfp_pkg;
  typedef enum logic [1:0] {
    CC_OPEN = 2'd0,
    CC_RD   = 2'd1,
    CC_RA   = 2'd2
  } cc_cls_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_LINKED = 1'b1
  } attach_st_e;

  typedef enum logic [1:0] {
    ADV_DEFAULT = 2'd0,
    ADV_MID     = 2'd1,
    ADV_HIGH    = 2'd2
  } adv_e;

  // Rd takes precedence when both comparators fire.
  function automatic cc_cls_e classify(input logic rd, input logic ra);
    if (rd)      return CC_RD;
    else if (ra) return CC_RA;
    else         return CC_OPEN;
  endfunction
endpackage

// File: rtl/tcdfp_cc_filter.sv
module tcdfp_cc_filter
  import tcdfp_pkg::*;
#(
  parameter int DEB_CYCLES = 1000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rd,
  input  logic    ra,
  output cc_cls_e cls_q
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  cc_cls_e       raw;
  cc_cls_e       cand;
  logic [CW-1:0] cnt;

  assign raw = classify(rd, ra);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand  <= CC_OPEN;
      cnt   <= '0;
      cls_q <= CC_OPEN;
    end else if (raw != cand) begin
      cand <= raw;
      cnt  <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end else begin
      cls_q <= cand;
    end
  end
endmodule

// File: rtl/tcdfp_attach_fsm.sv
module tcdfp_attach_fsm
  import tcdfp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cc_cls_e cls1,
  input  cc_cls_e cls2,
  output logic    linked,
  output logic    flip
);
  attach_st_e st;
  cc_cls_e    sel_cls;

  assign sel_cls = flip ? cls2 : cls1;
  assign linked  = (st == ST_LINKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      flip <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cls1 == CC_RD) begin
            st   <= ST_LINKED;
            flip <= 1'b0;
          end else if (cls2 == CC_RD) begin
            st   <= ST_LINKED;
            flip <= 1'b1;
          end
        end
        ST_LINKED: begin
          if (sel_cls != CC_RD) begin
            st   <= ST_IDLE;
            flip <= 1'b0;
          end
        end
        default: begin
          st   <= ST_IDLE;
          flip <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tcdfp_vconn_guard.sv
module tcdfp_vconn_guard #(
  parameter int FAULT_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic linked,
  input  logic fault_n,
  output logic tripped
);
  localparam int FW = $clog2(FAULT_CYCLES + 1);
  localparam logic [FW-1:0] LAST = FW'(FAULT_CYCLES - 1);

  logic [FW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !linked) begin
      cnt     <= '0;
      tripped <= 1'b0;
    end else if (!tripped) begin
      if (!fault_n) begin
        if (cnt == LAST) tripped <= 1'b1;
        else             cnt     <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/tcdfp_attach_ctrl.sv
module tcdfp_attach_ctrl
  import tcdfp_pkg::*;
#(
  parameter int DEB_CYCLES   = 1000,
  parameter int FAULT_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cc1_rd,
  input  logic       cc1_ra,
  input  logic       cc2_rd,
  input  logic       cc2_ra,
  input  logic       mode_a,
  input  logic       mode_b,
  input  logic       vbus_pol_strap,
  input  logic       vconn_pol_strap,
  input  logic       vconn_fault_n,
  input  logic       vbus_fault_n,
  output logic       hs_sel,
  output logic       hs_oe_n,
  output logic       ccmux_sel,
  output logic       ccmux_oe_n,
  output logic       vbus_en,
  output logic       vconn1_ctl,
  output logic       vconn2_ctl,
  output logic       attach_led,
  output logic [1:0] cur_adv
);
  localparam int NLINES = 2;

  logic    [NLINES-1:0] rd_v;
  logic    [NLINES-1:0] ra_v;
  cc_cls_e              cls [NLINES];
  logic                 linked;
  logic                 flip;
  logic                 tripped;
  logic                 vbus_pol_q;
  logic                 vconn_pol_q;
  logic                 v1_on;
  logic                 v2_on;
  adv_e                 adv;

  assign rd_v = {cc2_rd, cc1_rd};
  assign ra_v = {cc2_ra, cc1_ra};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    tcdfp_cc_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (rd_v[i]),
      .ra    (ra_v[i]),
      .cls_q (cls[i])
    );
  end

  tcdfp_attach_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cls1   (cls[0]),
    .cls2   (cls[1]),
    .linked (linked),
    .flip   (flip)
  );

  tcdfp_vconn_guard #(.FAULT_CYCLES(FAULT_CYCLES)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .linked  (linked),
    .fault_n (vconn_fault_n),
    .tripped (tripped)
  );

  // Straps are captured for as long as reset is held low.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbus_pol_q  <= vbus_pol_strap;
      vconn_pol_q <= vconn_pol_strap;
    end
  end

  always_comb begin
    case ({mode_a, mode_b})
      2'b01:   adv = ADV_MID;
      2'b11:   adv = ADV_HIGH;
      default: adv = ADV_DEFAULT;
    endcase
  end

  assign v1_on = linked &  flip & (cls[0] == CC_RA) & ~tripped;
  assign v2_on = linked & ~flip & (cls[1] == CC_RA) & ~tripped;

  assign hs_sel     = linked & flip;
  assign ccmux_sel  = linked & flip;
  assign hs_oe_n    = ~linked;
  assign ccmux_oe_n = ~linked;
  assign attach_led = linked;
  assign vbus_en    = linked ^ vbus_pol_q;
  assign vconn1_ctl = v1_on ^ vconn_pol_q;
  assign vconn2_ctl = v2_on ^ vconn_pol_q;
  assign cur_adv    = adv;
endmodule

// File: rtl/tcdfp_attach_ctrl_chk.sv
module tcdfp_attach_ctrl_chk #(
  parameter int FAULT_CYCLES = 500000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vbus_pol_strap,
  input logic       vconn_pol_strap,
  input logic       vconn_fault_n,
  input logic       vbus_fault_n,
  input logic       hs_sel,
  input logic       hs_oe_n,
  input logic       ccmux_sel,
  input logic       ccmux_oe_n,
  input logic       vbus_en,
  input logic       vconn1_ctl,
  input logic       vconn2_ctl,
  input logic       attach_led,
  input logic [1:0] cur_adv
);
  localparam int FW = $clog2(FAULT_CYCLES + 1);

  logic          pv;
  logic          pc;
  logic          a1;
  logic          a2;
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= vbus_pol_strap;
      pc <= vconn_pol_strap;
    end
  end

  assign a1 = vconn1_ctl ^ pc;
  assign a2 = vconn2_ctl ^ pc;

  always_ff @(posedge clk) begin
    if (!rst_n || vconn_fault_n || !attach_led) fcnt <= '0;
    else if (fcnt != FW'(FAULT_CYCLES)) fcnt <= fcnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !attach_led |-> (hs_oe_n && ccmux_oe_n && !hs_sel && !ccmux_sel && !a1 && !a2)); // R1
  AST_SEL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sel == ccmux_sel); // R3
  AST_OE_FOLLOWS_LED: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_oe_n == !attach_led) && (ccmux_oe_n == !attach_led)); // R4
  AST_VBUS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_en == (attach_led ^ pv)); // R5
  AST_VCONN_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a1 && a2)); // R6
  AST_VCONN1_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    a1 |-> (attach_led && hs_sel)); // R6
  AST_VCONN2_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    a2 |-> (attach_led && !hs_sel)); // R6
  AST_CUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_adv != 2'b11); // R8
  AST_FAULT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == FW'(FAULT_CYCLES)) |-> (!a1 && !a2)); // R9
  AST_VBUS_FAULT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbus_fault_n && attach_led) |-> (vbus_en == !pv)); // R10
endmodule

bind tcdfp_attach_ctrl tcdfp_attach_ctrl_chk #(.FAULT_CYCLES(FAULT_CYCLES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .vbus_pol_strap  (vbus_pol_strap),
  .vconn_pol_strap (vconn_pol_strap),
  .vconn_fault_n   (vconn_fault_n),
  .vbus_fault_n    (vbus_fault_n),
  .hs_sel          (hs_sel),
  .hs_oe_n         (hs_oe_n),
  .ccmux_sel       (ccmux_sel),
  .ccmux_oe_n      (ccmux_oe_n),
  .vbus_en         (vbus_en),
  .vconn1_ctl      (vconn1_ctl),
  .vconn2_ctl      (vconn2_ctl),
  .attach_led      (attach_led),
  .cur_adv         (cur_adv)
);

// File: tb/tcdfp_attach_ctrl_test.sv
module tcdfp_attach_ctrl_test;
  localparam int DEB = 4;
  localparam int FLT = 32;
  localparam int NV  = 9;

  // Row layout: cc1[11:10] cc2[9:8] mode[7:6] att[5] sel[4] v1[3] v2[2] cur[1:0]
  // CC class: 0 open, 1 Rd, 2 Ra
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd1, 2'd0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
    {2'd1, 2'd2, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2},
    {2'd2, 2'd1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    {2'd0, 2'd1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    {2'd0, 2'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    {2'd1, 2'd1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2},
    {2'd2, 2'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd2, 2'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cc1_rd = 1'b0, cc1_ra = 1'b0, cc2_rd = 1'b0, cc2_ra = 1'b0;
  logic mode_a = 1'b0, mode_b = 1'b0;
  logic vbus_pol_strap = 1'b0, vconn_pol_strap = 1'b0;
  logic vconn_fault_n = 1'b1, vbus_fault_n = 1'b1;
  logic hs_sel, hs_oe_n, ccmux_sel, ccmux_oe_n, vbus_en;
  logic vconn1_ctl, vconn2_ctl, attach_led;
  logic [1:0] cur_adv;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tcdfp_attach_ctrl #(.DEB_CYCLES(DEB), .FAULT_CYCLES(FLT)) uut (
    .clk(clk), .rst_n(rst_n),
    .cc1_rd(cc1_rd), .cc1_ra(cc1_ra), .cc2_rd(cc2_rd), .cc2_ra(cc2_ra),
    .mode_a(mode_a), .mode_b(mode_b),
    .vbus_pol_strap(vbus_pol_strap), .vconn_pol_strap(vconn_pol_strap),
    .vconn_fault_n(vconn_fault_n), .vbus_fault_n(vbus_fault_n),
    .hs_sel(hs_sel), .hs_oe_n(hs_oe_n), .ccmux_sel(ccmux_sel),
    .ccmux_oe_n(ccmux_oe_n), .vbus_en(vbus_en), .vconn1_ctl(vconn1_ctl),
    .vconn2_ctl(vconn2_ctl), .attach_led(attach_led), .cur_adv(cur_adv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cc(input logic [1:0] c1, input logic [1:0] c2);
    cc1_rd = (c1 == 2'd1); cc1_ra = (c1 == 2'd2);
    cc2_rd = (c2 == 2'd1); cc2_ra = (c2 == 2'd2);
  endtask

  task automatic do_reset(input logic pv, input logic pc);
    @(negedge clk);
    rst_n = 1'b0;
    vbus_pol_strap = pv;
    vconn_pol_strap = pc;
    set_cc(2'd0, 2'd0);
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    bit seen;
    do_reset(1'b0, 1'b0);
    // R1 reset state
    chk("R1 led", attach_led, 0);
    chk("R1 oe", {hs_oe_n, ccmux_oe_n}, 2'b11);
    chk("R1 sel", {hs_sel, ccmux_sel}, 2'b00);
    chk("R1 vbus", vbus_en, 0);
    chk("R1 vconn", {vconn1_ctl, vconn2_ctl}, 2'b00);

    // Vector table: R3 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      set_cc(v[11:10], v[9:8]);
      {mode_a, mode_b} = v[7:6];
      wait_cyc(30);
      chk("R5 attach", attach_led, v[5]);
      chk("R5 vbus", vbus_en, v[5]);
      chk("R3 sel", {hs_sel, ccmux_sel}, {v[4], v[4]});
      chk("R4 oe", {hs_oe_n, ccmux_oe_n}, {~v[5], ~v[5]});
      chk("R6 vconn", {vconn1_ctl, vconn2_ctl}, v[3:2]);
      chk("R8 cur", cur_adv, v[1:0]);
    end

    // R4: enables drop on the very sample LED rises
    set_cc(2'd0, 2'd0);
    wait_cyc(20);
    set_cc(2'd0, 2'd1);
    seen = 1'b0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (attach_led) begin
        seen = 1'b1;
        chk("R4 oe same cycle", {hs_oe_n, ccmux_oe_n}, 2'b00);
      end else begin
        chk("R4 oe before attach", {hs_oe_n, ccmux_oe_n}, 2'b11);
      end
    end
    chk("R4 attach reached", seen, 1);

    // R2: glitches shorter than the window
    set_cc(2'd0, 2'd0);
    wait_cyc(20);
    set_cc(2'd1, 2'd0);
    wait_cyc(2);
    set_cc(2'd0, 2'd0);
    wait_cyc(15);
    chk("R2 attach glitch", attach_led, 0);
    set_cc(2'd1, 2'd2);
    wait_cyc(20);
    chk("R2 attached", attach_led, 1);
    set_cc(2'd0, 2'd2);
    wait_cyc(2);
    set_cc(2'd1, 2'd2);
    wait_cyc(15);
    chk("R2 detach glitch", attach_led, 1);

    // R9: short fault ignored, long fault latches
    chk("R9 vconn on", vconn2_ctl, 1);
    vconn_fault_n = 1'b0;
    wait_cyc(FLT - 8);
    chk("R9 during short fault", vconn2_ctl, 1);
    vconn_fault_n = 1'b1;
    wait_cyc(3);
    chk("R9 after short fault", vconn2_ctl, 1);
    vconn_fault_n = 1'b0;
    wait_cyc(FLT + 8);
    chk("R9 long fault off", {vconn1_ctl, vconn2_ctl}, 2'b00);
    vconn_fault_n = 1'b1;
    wait_cyc(10);
    chk("R9 latched", {vconn1_ctl, vconn2_ctl}, 2'b00);
    chk("R9 still attached", attach_led, 1);

    // R11: detach clears latch
    set_cc(2'd0, 2'd2);
    wait_cyc(20);
    chk("R11 detached", attach_led, 0);
    set_cc(2'd1, 2'd2);
    wait_cyc(20);
    chk("R11 vconn back", vconn2_ctl, 1);

    // R10: VBUS fault has no effect
    vbus_fault_n = 1'b0;
    wait_cyc(10);
    chk("R10 attached", {attach_led, vbus_en, vconn2_ctl}, 3'b111);
    set_cc(2'd0, 2'd0);
    wait_cyc(20);
    chk("R10 unattached", {attach_led, vbus_en}, 2'b00);
    vbus_fault_n = 1'b1;

    // R7: active-low straps, later changes ignored
    do_reset(1'b1, 1'b1);
    chk("R7 idle levels", {vbus_en, vconn1_ctl, vconn2_ctl}, 3'b111);
    vbus_pol_strap = 1'b0;
    vconn_pol_strap = 1'b0;
    wait_cyc(3);
    chk("R7 strap ignored idle", {vbus_en, vconn1_ctl, vconn2_ctl}, 3'b111);
    set_cc(2'd2, 2'd1);
    wait_cyc(20);
    chk("R7 active low attached", {vbus_en, vconn1_ctl, vconn2_ctl}, 3'b001);
    chk("R7 sel", hs_sel, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule